// File: doc/BRIEF.md
# Reduced-Round PRINCE Encryption Core

This block encrypts one 64-bit block under a 128-bit key. It uses the PRINCE construction: input whitening, then a set of forward half-rounds, a middle involution layer, a mirrored set of inverse half-rounds, and output whitening. The number of half-rounds on each side is the parameter `HALF_ROUNDS`, from 0 to 5, with a default of 2. The round keys do not all equal the lower key half. Instead they alternate between the upper half k0 and the lower half k1 according to the parity of the round index.

The core is iterative. It performs one layer per clock cycle and keeps the key in a register for the whole operation. A block is accepted when `in_valid` and `in_ready` are both high at a clock edge. While the core is working, `busy` is high and `in_ready` is low. When the result is ready, `out_valid` pulses for one cycle. `out_data` then keeps the ciphertext until the next block is accepted. Only encryption is provided.

Top module: `prince_lite`

## Requirements
- R1: After reset, `in_ready` is 1, `busy` is 0 and `out_valid` is 0.
- R2: The key splits as k0 = `in_key[127:64]` and k1 = `in_key[63:0]`. Input whitening XORs the block with k0, k1 and round constant 0, which is all zeros.
- R3: Forward half-round h (h = 0 .. N-1) has round index i = 1+h. It applies these steps in order: the forward S-box on every nibble, the M' layer, shift-rows, XOR with constant i, and XOR with k0 if i is odd or with k1 if i is even. Shift-rows sets output nibble n to input nibble src[n], with src = 4,9,14,3,8,13,2,7,12,1,6,11,0,5,10,15. The forward S-box maps 0..15 to b,f,3,2,a,c,9,1,6,7,8,0,e,5,d,4.
- R4: The middle layer applies the forward S-box, then M', then the inverse S-box. M' works on each 16-bit quarter q separately. Output nibble j of a quarter is the XOR of the four nibbles of (q AND mask). The mask is taken from the list 7bde, bde7, de7b, e7bd at position (s+3-j) mod 4, where s = 0 for quarters 0 and 3 and s = 1 for quarters 1 and 2.
- R5: Inverse half-round h (h = 0 .. N-1) has round index i = 11-N+h. It applies these steps in order: XOR with k1 if i is odd or with k0 if i is even, XOR with constant i, inverse shift-rows (src = 12,9,6,3,0,13,10,7,4,1,14,11,8,5,2,15), M', and the inverse S-box (0..15 maps to b,7,3,2,f,d,8,9,a,6,4,0,5,e,c,1).
- R6: Output whitening XORs with constant 11, with k1, and with k0' = (k0 rotated right by 1) XOR (k0 >> 63).
- R7: After a block is accepted, `busy` is high and `in_ready` is low. Exactly 2N+2 clock edges after the accepting edge, `busy` returns to 0, `in_ready` returns to 1 and `out_valid` is 1.
- R8: An `in_valid` presented while `busy` is high is refused and ignored. The result that follows belongs to the earlier block, and the refused block produces no later `out_valid`.
- R9: `out_valid` is high for exactly one cycle per accepted block. `out_data` keeps its value until the next block completes.
- R10: `HALF_ROUNDS` = 0, 2 and 5 all produce the cipher described in R2 to R6 with that N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A plaintext block and key are offered |
| in_ready | output | 1 | The core is idle and will accept a block |
| in_data | input | 64 | Plaintext block |
| in_key | input | 128 | Key, k0 in the upper half and k1 in the lower half |
| busy | output | 1 | An encryption is in progress |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a new ciphertext |
| out_data | output | 64 | Ciphertext, held until the next result |

## Verification
Ciphertexts are compared with a reference model for an all-zero block and key, for keys where only k0 or only k1 is nonzero, and for random blocks and keys. The zero-key cases separate the round-key parity choice and the k0' whitening from the constant path. The random cases cover the S-box, M' and shift-rows indexing. The same patterns run on cores built with zero, two and five half-rounds. The zero-round core shows that the middle layer and whitening are correct on their own, and the five-round core covers every constant index. A block offered during an operation shows that the core refuses it and that the result and the count of output pulses are unchanged.

// File: rtl/prince_lite.sv
module prince_lite #(
  parameter int HALF_ROUNDS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [63:0]  in_data,
  input  logic [127:0] in_key,
  output logic         busy,
  output logic         out_valid,
  output logic [63:0]  out_data
);
  localparam int LAST = 2 * HALF_ROUNDS + 1;
  localparam int SW   = $clog2(LAST + 1);

  function automatic logic [3:0] sb_f(input logic [3:0] x);
    case (x)
      4'h0: return 4'hb; 4'h1: return 4'hf; 4'h2: return 4'h3; 4'h3: return 4'h2;
      4'h4: return 4'ha; 4'h5: return 4'hc; 4'h6: return 4'h9; 4'h7: return 4'h1;
      4'h8: return 4'h6; 4'h9: return 4'h7; 4'ha: return 4'h8; 4'hb: return 4'h0;
      4'hc: return 4'he; 4'hd: return 4'h5; 4'he: return 4'hd; default: return 4'h4;
    endcase
  endfunction

  function automatic logic [3:0] sb_i(input logic [3:0] x);
    case (x)
      4'h0: return 4'hb; 4'h1: return 4'h7; 4'h2: return 4'h3; 4'h3: return 4'h2;
      4'h4: return 4'hf; 4'h5: return 4'hd; 4'h6: return 4'h8; 4'h7: return 4'h9;
      4'h8: return 4'ha; 4'h9: return 4'h6; 4'ha: return 4'h4; 4'hb: return 4'h0;
      4'hc: return 4'h5; 4'hd: return 4'he; 4'he: return 4'hc; default: return 4'h1;
    endcase
  endfunction

  function automatic logic [63:0] sub_fwd(input logic [63:0] x);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = sb_f(x[4*n +: 4]);
    return r;
  endfunction

  function automatic logic [63:0] sub_inv(input logic [63:0] x);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = sb_i(x[4*n +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] mask_at(input int k);
    case (k)
      0: return 16'h7bde;
      1: return 16'hbde7;
      2: return 16'hde7b;
      default: return 16'he7bd;
    endcase
  endfunction

  function automatic logic [63:0] mlin(input logic [63:0] x);
    logic [63:0] r;
    logic [15:0] q, m;
    int s;
    for (int b = 0; b < 4; b++) begin
      q = x[16*b +: 16];
      s = (b == 0 || b == 3) ? 0 : 1;
      for (int j = 0; j < 4; j++) begin
        m = q & mask_at((s + 3 - j) % 4);
        r[16*b + 4*j +: 4] = m[3:0] ^ m[7:4] ^ m[11:8] ^ m[15:12];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] rows_fwd(input logic [63:0] x);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = x[4*((5*n + 4) % 16) +: 4];
    return r;
  endfunction

  function automatic logic [63:0] rows_inv(input logic [63:0] x);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = x[4*((13*n + 12) % 16) +: 4];
    return r;
  endfunction

  function automatic logic [63:0] rcon(input int i);
    case (i)
      1:  return 64'h13198a2e03707344;
      2:  return 64'ha4093822299f31d0;
      3:  return 64'h082efa98ec4e6c89;
      4:  return 64'h452821e638d01377;
      5:  return 64'hbe5466cf34e90c6c;
      6:  return 64'h7ef84f78fd955cb1;
      7:  return 64'h85840851f1ac43aa;
      8:  return 64'hc882d32f25323c54;
      9:  return 64'h64a51195e0e3610d;
      10: return 64'hd3b5a399ca0c2399;
      11: return 64'hc0ac29b7c97c50dd;
      default: return 64'h0;
    endcase
  endfunction

  logic [63:0]   st, nxt, k0, k1, k0p;
  logic [SW-1:0] step;
  logic          last_step;

  assign k0p       = {k0[0], k0[63:1]} ^ {63'd0, k0[63]};
  assign in_ready  = ~busy;
  assign last_step = (int'(step) == LAST);

  always_comb begin
    int s, idx;
    s   = int'(step);
    idx = 0;
    if (s < HALF_ROUNDS) begin
      idx = 1 + s;
      nxt = rows_fwd(mlin(sub_fwd(st))) ^ rcon(idx) ^ (idx[0] ? k0 : k1);
    end else if (s == HALF_ROUNDS) begin
      nxt = sub_inv(mlin(sub_fwd(st)));
    end else if (s < LAST) begin
      idx = 10 - 2 * HALF_ROUNDS + s;
      nxt = sub_inv(mlin(rows_inv(st ^ (idx[0] ? k1 : k0) ^ rcon(idx))));
    end else begin
      nxt = st ^ rcon(11) ^ k1 ^ k0p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      k0        <= '0;
      k1        <= '0;
      step      <= '0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          k0   <= in_key[127:64];
          k1   <= in_key[63:0];
          st   <= in_data ^ in_key[127:64] ^ in_key[63:0];
          step <= '0;
          busy <= 1'b1;
        end
      end else begin
        st <= nxt;
        if (last_step) begin
          out_data  <= nxt;
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));
  p_done_with_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $fell(busy));
  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(step) <= LAST));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && last_step) |=> $stable(out_data));
  p_key_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(k0) && $stable(k1)));
endmodule

// File: tb/prince_lite_tb.sv
module prince_lite_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [63:0]  in_data = '0;
  logic [127:0] in_key = '0;
  logic iv [3];
  logic ir [3];
  logic bz [3];
  logic ov [3];
  logic [63:0] od [3];
  int NS [3] = '{2, 0, 5};
  int errors = 0, checks = 0;
  bit done = 0;

  prince_lite #(.HALF_ROUNDS(2)) u_dut (.clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]),
    .in_data(in_data), .in_key(in_key), .busy(bz[0]), .out_valid(ov[0]), .out_data(od[0]));
  prince_lite #(.HALF_ROUNDS(0)) u_dut_n0 (.clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]),
    .in_data(in_data), .in_key(in_key), .busy(bz[1]), .out_valid(ov[1]), .out_data(od[1]));
  prince_lite #(.HALF_ROUNDS(5)) u_dut_n5 (.clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(ir[2]),
    .in_data(in_data), .in_key(in_key), .busy(bz[2]), .out_valid(ov[2]), .out_data(od[2]));

  logic [3:0] SBF [16] = '{4'hb,4'hf,4'h3,4'h2,4'ha,4'hc,4'h9,4'h1,4'h6,4'h7,4'h8,4'h0,4'he,4'h5,4'hd,4'h4};
  logic [3:0] SBI [16] = '{4'hb,4'h7,4'h3,4'h2,4'hf,4'hd,4'h8,4'h9,4'ha,4'h6,4'h4,4'h0,4'h5,4'he,4'hc,4'h1};
  int SRF [16] = '{4,9,14,3,8,13,2,7,12,1,6,11,0,5,10,15};
  int SRI [16] = '{12,9,6,3,0,13,10,7,4,1,14,11,8,5,2,15};
  logic [15:0] MSK [4] = '{16'h7bde,16'hbde7,16'hde7b,16'he7bd};
  logic [63:0] RC [12] = '{64'h0, 64'h13198a2e03707344, 64'ha4093822299f31d0, 64'h082efa98ec4e6c89,
    64'h452821e638d01377, 64'hbe5466cf34e90c6c, 64'h7ef84f78fd955cb1, 64'h85840851f1ac43aa,
    64'hc882d32f25323c54, 64'h64a51195e0e3610d, 64'hd3b5a399ca0c2399, 64'hc0ac29b7c97c50dd};

  function automatic logic [63:0] m_sub(input logic [63:0] x, input bit inv);
    for (int n = 0; n < 16; n++) x[4*n +: 4] = inv ? SBI[x[4*n +: 4]] : SBF[x[4*n +: 4]];
    return x;
  endfunction
  function automatic logic [63:0] m_rows(input logic [63:0] x, input bit inv);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = x[4*(inv ? SRI[n] : SRF[n]) +: 4];
    return r;
  endfunction
  function automatic logic [63:0] m_lin(input logic [63:0] x);
    logic [63:0] r = '0;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 4; j++) begin
        logic [15:0] m;
        m = x[16*b +: 16] & MSK[(((b == 0 || b == 3) ? 0 : 1) + 3 - j) % 4];
        r[16*b + 4*j +: 4] = m[3:0] ^ m[7:4] ^ m[11:8] ^ m[15:12];
      end
    return r;
  endfunction
  function automatic logic [63:0] model(input logic [63:0] d, input logic [127:0] k, input int n);
    logic [63:0] k0 = k[127:64], k1 = k[63:0], k0p;
    k0p = {k0[0], k0[63:1]} ^ {63'd0, k0[63]};
    d = d ^ k0 ^ k1 ^ RC[0];
    for (int h = 0; h < n; h++) begin
      int i = 1 + h;
      d = m_rows(m_lin(m_sub(d, 0)), 0) ^ RC[i] ^ ((i % 2 == 1) ? k0 : k1);
    end
    d = m_sub(m_lin(m_sub(d, 0)), 1);
    for (int h = 0; h < n; h++) begin
      int i = 11 - n + h;
      d = d ^ ((i % 2 == 1) ? k1 : k0) ^ RC[i];
      d = m_sub(m_lin(m_rows(d, 1)), 1);
    end
    return d ^ RC[11] ^ k1 ^ k0p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int u, input logic [63:0] d, input logic [127:0] k, input string tag);
    int cnt = 0;
    logic [63:0] exp = model(d, k, NS[u]);
    @(negedge clk);
    in_data = d; in_key = k; iv[u] = 1;
    @(posedge clk); #1;
    iv[u] = 0;
    chk(bz[u] && !ir[u], "R7 busy after accept", 64'(bz[u]), 64'd1);
    while (bz[u] && cnt < 40) begin @(posedge clk); #1; cnt++; end
    chk(cnt == 2 * NS[u] + 2, "R7 latency", 64'(cnt), 64'(2 * NS[u] + 2));
    chk(ov[u] && ir[u], "R7 R9 valid and ready at end", 64'(ov[u]), 64'd1);
    chk(od[u] === exp, {tag, " R2 R3 R4 R5 R6 R10 ciphertext"}, od[u], exp);
    @(posedge clk); #1;
    chk(!ov[u] && od[u] === exp, "R9 one-cycle pulse, data held", 64'(ov[u]), 64'd0);
  endtask

  task automatic run_refuse(input int u);
    logic [63:0] a = 64'h0123456789abcdef, b = 64'hfedcba9876543210;
    logic [127:0] k = {64'h0011223344556677, 64'h8899aabbccddeeff};
    logic [63:0] exp = model(a, k, NS[u]);
    int pulses = 0;
    @(negedge clk);
    in_data = a; in_key = k; iv[u] = 1;
    @(posedge clk); #1;
    iv[u] = 0;
    @(negedge clk);
    in_data = b; in_key = ~k; iv[u] = 1;
    #1 chk(!ir[u], "R8 ready low while busy", 64'(ir[u]), 64'd0);
    @(negedge clk);
    iv[u] = 0;
    for (int c = 0; c < 2 * NS[u] + 8; c++) begin
      @(posedge clk); #1;
      if (ov[u]) pulses++;
    end
    chk(pulses == 1, "R8 single result for refused block", 64'(pulses), 64'd1);
    chk(od[u] === exp, "R8 result belongs to first block", od[u], exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 3; u++) iv[u] = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int u = 0; u < 3; u++)
      chk(ir[u] && !bz[u] && !ov[u], "R1 reset state", {61'd0, ir[u], bz[u], ov[u]}, 64'h4);
    @(negedge clk); rst_n = 1;
    for (int u = 0; u < 3; u++) begin
      run_vec(u, 64'h0, 128'h0, "zero");
      run_vec(u, 64'h0, {64'h0, 64'hffffffffffffffff}, "k1 only");
      run_vec(u, 64'h0, {64'h8000000000000001, 64'h0}, "k0 only");
      run_vec(u, 64'hffffffffffffffff, 128'h0, "ones data");
      for (int r = 0; r < 6; r++)
        run_vec(u, {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, "random");
      run_refuse(u);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule